// File: doc/BRIEF.md
# Banked and Indirect Data Address Generator

This block forms the 12-bit data-space address for every operand access of a small accumulator-style processor whose instructions carry only an 8-bit register field. A direct operand is either placed in a shared access window or extended with a 4-bit bank number held in a bank register. The access window is the lower half of page 0 plus the upper half of page 15, where the special function registers live. Three 12-bit pointer registers give indirect access. Each pointer has five alias locations near the top of the data space. When the direct address lands on one of them, the block switches to indirect mode and computes the pointed-to address. For some aliases it also moves the pointer.

The surrounding core presents one operand per cycle with `op_valid`. It reads the effective address combinationally in the same cycle. Any pointer movement is committed at the following clock edge. Software loads the bank and pointer registers through plain write strobes, and their current values are always visible on the outputs. The RAM array and the peripheral registers lie outside this block. The `ea_null` flag tells the data path to return zero for an indirect access whose target is itself an alias.

Top module: `data_addr_gen`

## Requirements
- R1: With `op_banked`=0 and `op_field` in 0x00–0x7F, `ea` equals {4'h0, op_field} and `ea_indirect` is 0.
- R2: With `op_banked`=0 and `op_field` in 0x80–0xFF, the direct address is {4'hF, op_field}. This upper part of the access window reaches the special function register page.
- R3: With `op_banked`=1, the direct address is {bank_q, op_field}. `bank_q` resets to 0 and is loaded with `bank_wdata` one edge after `bank_we`=1.
- R4: Pointers P0, P1 and P2 are 12 bits wide and reset to 0. `ptr_we`=1 loads `ptr_wdata` into the pointer chosen by `ptr_sel` (0–2); `ptr_sel`=3 changes nothing. A write wins over an automatic update of the same pointer in the same cycle. `ptr_q` is {P2,P1,P0}.
- R5: The alias locations are 0xFD8+8·k+m, where k is the pointer (0–2) and m is the mode (0–4). A direct address equal to one of them sets `ea_indirect`=1. Offsets m=5–7 are ordinary direct addresses.
- R6: Mode m=0 (plain) gives `ea`=Pk and leaves Pk unchanged.
- R7: Mode m=1 (post-increment) gives `ea`=Pk and then sets Pk to (Pk+1) mod 4096.
- R8: Mode m=2 (post-decrement) gives `ea`=Pk and then sets Pk to (Pk−1) mod 4096.
- R9: Mode m=3 (pre-increment) gives `ea`=(Pk+1) mod 4096 and sets Pk to that same value.
- R10: Mode m=4 (plus-W) gives `ea`=(Pk+`w_val`) mod 4096, with `w_val` unsigned, and leaves Pk unchanged.
- R11: When the indirect address is itself an alias location, `ea_null`=1 and no pointer changes.
- R12: With `op_valid`=0, `ea` is still computed, but no pointer changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operand access is made this cycle |
| op_field | input | 8 | Register field of the instruction |
| op_banked | input | 1 | 1 = banked direct, 0 = access window |
| w_val | input | 8 | Working register value, used as the plus-W offset |
| bank_we | input | 1 | Load the bank register |
| bank_wdata | input | 4 | New bank number |
| ptr_we | input | 1 | Load a pointer register |
| ptr_sel | input | 2 | Pointer to load (0–2) |
| ptr_wdata | input | 12 | New pointer value |
| ea | output | 12 | Effective data address |
| ea_indirect | output | 1 | Operand went through a pointer alias |
| ea_null | output | 1 | Nested alias: the read returns zero, no update |
| bank_q | output | 4 | Current bank register |
| ptr_q | output | 36 | Current pointers {P2,P1,P0} |

## Verification
The assertions assume that every input is settled and known at each rising edge while reset is released. They also assume that the core may drive `ptr_sel`=3 and may write a pointer in the same cycle as an automatic update of that pointer. The stimulus changes inputs only on falling edges. It draws register fields mostly from the alias neighbourhood 0xD0–0xEF so that every pointer mode is exercised often. It loads pointers with values near the alias range and near the 0xFFF/0x000 wrap, so that nested aliases and modular arithmetic occur regularly.

// File: rtl/dag_pkg.sv
package dag_pkg;

  localparam int DAG_ADDR_W  = 12;
  localparam int DAG_FIELD_W = 8;

  typedef logic [DAG_ADDR_W-1:0]  daddr_t;
  typedef logic [DAG_FIELD_W-1:0] dfield_t;

  typedef enum logic [2:0] {
    IND_PLAIN   = 3'd0,
    IND_POSTINC = 3'd1,
    IND_POSTDEC = 3'd2,
    IND_PREINC  = 3'd3,
    IND_PLUSW   = 3'd4
  } ind_mode_e;

  // Address the operand reaches through a pointer in a given mode.
  function automatic daddr_t ind_target(daddr_t p, ind_mode_e m, dfield_t w);
    daddr_t r;
    case (m)
      IND_PREINC: r = p + daddr_t'(1);
      IND_PLUSW:  r = p + {{(DAG_ADDR_W-DAG_FIELD_W){1'b0}}, w};
      default:    r = p;
    endcase
    return r;
  endfunction

  // Pointer value after the access, wrapping modulo the data space.
  function automatic daddr_t ptr_after(daddr_t p, ind_mode_e m);
    daddr_t r;
    case (m)
      IND_POSTINC, IND_PREINC: r = p + daddr_t'(1);
      IND_POSTDEC:             r = p - daddr_t'(1);
      default:                 r = p;
    endcase
    return r;
  endfunction

  function automatic logic mode_moves(ind_mode_e m);
    return (m == IND_POSTINC) || (m == IND_POSTDEC) || (m == IND_PREINC);
  endfunction

endpackage

// File: rtl/dag_direct.sv
module dag_direct #(
  parameter int ADDR_W  = 12,
  parameter int FIELD_W = 8,
  parameter int BANK_W  = 4,
  parameter logic [FIELD_W-1:0] ACCESS_SPLIT = 8'h80
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               banked,
  input  logic [BANK_W-1:0]  bank,
  output logic [ADDR_W-1:0]  daddr
);

  localparam int HI_W = ADDR_W - FIELD_W;

  logic [HI_W-1:0] hi_part;

  always_comb begin
    if (banked)
      hi_part = HI_W'(bank);
    else if (field < ACCESS_SPLIT)
      hi_part = '0;
    else
      hi_part = '1;
  end

  assign daddr = {hi_part, field};

endmodule

// File: rtl/dag_alias_dec.sv
module dag_alias_dec
  import dag_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_PTR      = 3,
  parameter int ALIAS_STRIDE = 8,
  parameter int NUM_MODES    = 5,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 12'hFD8,
  localparam int IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output ind_mode_e         mode
);

  localparam int SH   = $clog2(ALIAS_STRIDE);
  localparam int SPAN = NUM_PTR * ALIAS_STRIDE;

  logic [ADDR_W-1:0] off;
  logic [SH-1:0]     slot;
  logic              in_rng;

  assign off    = addr - ALIAS_BASE;
  assign slot   = off[SH-1:0];
  assign in_rng = (addr >= ALIAS_BASE) && (off < ADDR_W'(SPAN));
  assign hit    = in_rng && (slot < SH'(NUM_MODES));
  assign idx    = off[SH +: IDX_W];
  assign mode   = ind_mode_e'(slot);

endmodule

// File: rtl/dag_ptr_bank.sv
module dag_ptr_bank #(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 4,
  parameter int NUM_PTR = 3,
  localparam int IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PTR-1:0]             upd_en,
  input  logic [ADDR_W-1:0]              upd_val,
  input  logic                           ptr_we,
  input  logic [IDX_W-1:0]               ptr_sel,
  input  logic [ADDR_W-1:0]              ptr_wdata,
  input  logic                           bank_we,
  input  logic [BANK_W-1:0]              bank_wdata,
  output logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_r,
  output logic [BANK_W-1:0]              bank_r
);

  logic [NUM_PTR-1:0] wr_hit;

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    assign wr_hit[k] = ptr_we && (ptr_sel == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_r[k] <= '0;
      else if (wr_hit[k])
        ptr_r[k] <= ptr_wdata;
      else if (upd_en[k])
        ptr_r[k] <= upd_val;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[k] && !upd_en[k]) |=> $stable(ptr_r[k])); // R6
    AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (ptr_r[k] == $past(ptr_wdata))); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bank_r <= '0;
    else if (bank_we)
      bank_r <= bank_wdata;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_r == $past(bank_wdata))); // R3

endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int FIELD_W      = 8,
  parameter int BANK_W       = 4,
  parameter int NUM_PTR      = 3,
  parameter int ALIAS_STRIDE = 8,
  parameter logic [ADDR_W-1:0]  ALIAS_BASE   = 12'hFD8,
  parameter logic [FIELD_W-1:0] ACCESS_SPLIT = 8'h80,
  localparam int IDX_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [FIELD_W-1:0]          op_field,
  input  logic                        op_banked,
  input  logic [FIELD_W-1:0]          w_val,
  input  logic                        bank_we,
  input  logic [BANK_W-1:0]           bank_wdata,
  input  logic                        ptr_we,
  input  logic [IDX_W-1:0]            ptr_sel,
  input  logic [ADDR_W-1:0]           ptr_wdata,
  output logic [ADDR_W-1:0]           ea,
  output logic                        ea_indirect,
  output logic                        ea_null,
  output logic [BANK_W-1:0]           bank_q,
  output logic [NUM_PTR*ADDR_W-1:0]   ptr_q
);

  localparam int NUM_MODES = 5;

  logic [ADDR_W-1:0]              daddr;
  logic                           ind_hit;
  logic [IDX_W-1:0]               ind_idx;
  ind_mode_e                      ind_mode;
  logic [ADDR_W-1:0]              cur_ptr;
  logic [ADDR_W-1:0]              ind_addr;
  logic                           nest_hit;
  logic [IDX_W-1:0]               nest_idx;
  ind_mode_e                      nest_mode;
  logic                           upd_go;
  logic [NUM_PTR-1:0]             upd_en;
  logic [ADDR_W-1:0]              upd_val;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_arr;

  dag_direct #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .BANK_W(BANK_W), .ACCESS_SPLIT(ACCESS_SPLIT)
  ) u_direct (
    .field(op_field), .banked(op_banked), .bank(bank_q), .daddr(daddr)
  );

  dag_alias_dec #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .ALIAS_STRIDE(ALIAS_STRIDE),
    .NUM_MODES(NUM_MODES), .ALIAS_BASE(ALIAS_BASE)
  ) u_alias (
    .addr(daddr), .hit(ind_hit), .idx(ind_idx), .mode(ind_mode)
  );

  always_comb begin
    cur_ptr = '0;
    for (int k = 0; k < NUM_PTR; k++)
      if (ind_idx == IDX_W'(k)) cur_ptr = ptr_arr[k];
  end

  assign ind_addr = ind_target(cur_ptr, ind_mode, w_val);
  assign upd_val  = ptr_after(cur_ptr, ind_mode);

  // Second decoder flags a pointer that aims back into the alias block.
  dag_alias_dec #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .ALIAS_STRIDE(ALIAS_STRIDE),
    .NUM_MODES(NUM_MODES), .ALIAS_BASE(ALIAS_BASE)
  ) u_nest (
    .addr(ind_addr), .hit(nest_hit), .idx(nest_idx), .mode(nest_mode)
  );

  assign upd_go = op_valid && ind_hit && !nest_hit && mode_moves(ind_mode);

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_upd
    assign upd_en[k] = upd_go && (ind_idx == IDX_W'(k));
  end

  dag_ptr_bank #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_PTR(NUM_PTR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_val(upd_val),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .bank_we(bank_we), .bank_wdata(bank_wdata),
    .ptr_r(ptr_arr), .bank_r(bank_q)
  );

  assign ea          = ind_hit ? ind_addr : daddr;
  assign ea_indirect = ind_hit;
  assign ea_null     = ind_hit && nest_hit;
  assign ptr_q       = ptr_arr;

  AST_ACCESS_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_banked && (op_field < ACCESS_SPLIT)) |-> (!ea_indirect && (ea == ADDR_W'(op_field)))); // R1
  AST_SINGLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_en)); // R7
  AST_NULL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ea_null |-> (upd_en == '0)); // R11
  AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (upd_en == '0)); // R12
  AST_NEST_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    nest_hit |-> ((nest_idx < IDX_W'(NUM_PTR)) && (nest_mode <= IND_PLUSW))); // R5
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && (ind_mode == IND_POSTINC) && !(ptr_we && (ptr_sel == ind_idx)))
    |=> (ptr_arr[$past(ind_idx)] == $past(cur_ptr) + ADDR_W'(1))); // R7

endmodule

// File: tb/test_data_addr_gen.sv
`timescale 1ns/1ps
module test_data_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_field = '0;
  logic        op_banked = 1'b0;
  logic [7:0]  w_val = '0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic        ptr_we = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [11:0] ptr_wdata = '0;
  logic [11:0] ea;
  logic        ea_indirect;
  logic        ea_null;
  logic [3:0]  bank_q;
  logic [35:0] ptr_q;

  int checks = 0;
  int errors = 0;
  int mp[3];
  int mbank;

  always #4 clk = ~clk;

  data_addr_gen i_data_addr_gen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_field(op_field),
    .op_banked(op_banked), .w_val(w_val), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .ptr_we(ptr_we), .ptr_sel(ptr_sel),
    .ptr_wdata(ptr_wdata), .ea(ea), .ea_indirect(ea_indirect),
    .ea_null(ea_null), .bank_q(bank_q), .ptr_q(ptr_q)
  );

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int ref_direct(int f, int b, int bk);
    if (b != 0) return bk * 256 + f;
    if (f >= 128) return 3840 + f;
    return f;
  endfunction

  // Returns 8*pointer+mode for an alias location, otherwise -1.
  function automatic int ref_alias(int a);
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 5; m++)
        if (a == 4056 + 8 * k + m) return 8 * k + m;
    return -1;
  endfunction

  task automatic step(int v, int f, int b, int w, int bwe, int bwd,
                      int pwe, int psel, int pwd);
    int da, al, k, m, p, xea, xnull, xind;
    string tag, rtag;
    op_valid = v[0]; op_field = f[7:0]; op_banked = b[0]; w_val = w[7:0];
    bank_we = bwe[0]; bank_wdata = bwd[3:0];
    ptr_we = pwe[0]; ptr_sel = psel[1:0]; ptr_wdata = pwd[11:0];
    #1;
    da = ref_direct(f, b, mbank);
    al = ref_alias(da);
    xnull = 0; xind = 0; xea = da; k = 0; m = 0;
    if (al < 0) begin
      tag = (b != 0) ? "R3" : ((f < 128) ? "R1" : "R2");
      if ((da & 4088) >= 4056 && (da & 4088) <= 4072 && (da & 7) > 4) tag = "R5";
    end else begin
      k = al / 8; m = al % 8; p = mp[k]; xind = 1;
      case (m)
        3: xea = (p + 1) % 4096;
        4: xea = (p + w) % 4096;
        default: xea = p;
      endcase
      case (m)
        0: tag = "R6"; 1: tag = "R7"; 2: tag = "R8"; 3: tag = "R9"; default: tag = "R10";
      endcase
      if (ref_alias(xea) >= 0) begin xnull = 1; tag = "R11"; end
    end
    chk(tag, 48'(ea), 48'(xea));
    chk(tag, 48'(ea_indirect), 48'(xind));
    chk(tag, 48'(ea_null), 48'(xnull));
    rtag = (v == 0) ? "R12" : tag;
    if (v != 0 && xind == 1 && xnull == 0) begin
      if (m == 1 || m == 3) mp[k] = (mp[k] + 1) % 4096;
      if (m == 2) mp[k] = (mp[k] + 4095) % 4096;
    end
    if (pwe != 0 && psel < 3) begin mp[psel] = pwd % 4096; rtag = "R4"; end
    if (bwe != 0) begin mbank = bwd % 16; rtag = "R3"; end
    @(posedge clk);
    @(negedge clk);
    chk(rtag, 48'(ptr_q), {12'h0, 12'(mp[2]), 12'(mp[1]), 12'(mp[0])});
    chk(rtag, 48'(bank_q), 48'(mbank));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mp[0] = 0; mp[1] = 0; mp[2] = 0; mbank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state of pointers and bank (R4, R3)
    chk("R4", 48'(ptr_q), 48'h0);
    chk("R3", 48'(bank_q), 48'h0);
    // R1 / R2 access window
    step(1, 8'h25, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'h9A, 0, 0, 0, 0, 0, 0, 0);
    // R3 bank load then banked use
    step(0, 0, 0, 0, 1, 5, 0, 0, 0);
    step(1, 8'h9B, 1, 0, 0, 0, 0, 0, 0);
    // R6 plain, R8 post-decrement on P2
    step(0, 0, 0, 0, 0, 0, 1, 2, 12'h3F2);
    step(1, 8'hE8, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hEA, 0, 0, 0, 0, 0, 0, 0);
    // R7 post-increment on P0
    step(0, 0, 0, 0, 0, 0, 1, 0, 12'h1BA);
    step(1, 8'hD9, 0, 0, 0, 0, 0, 0, 0);
    // R9 pre-increment, R10 plus-W on P1
    step(0, 0, 0, 0, 0, 0, 1, 1, 12'h22C);
    step(1, 8'hE3, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hE4, 0, 8'hFF, 0, 0, 0, 0, 0);
    // R7 / R8 wrap
    step(0, 0, 0, 0, 0, 0, 1, 0, 12'hFFF);
    step(1, 8'hD9, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hDA, 0, 0, 0, 0, 0, 0, 0);
    // R11 nested alias: plain target and pre-increment target
    step(0, 0, 0, 0, 0, 0, 1, 0, 12'hFD8);
    step(1, 8'hD9, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 12'hFD7);
    step(1, 8'hE3, 0, 0, 0, 0, 0, 0, 0);
    // R12 no update without op_valid
    step(0, 0, 0, 0, 0, 0, 1, 2, 12'h100);
    step(0, 8'hE9, 0, 0, 0, 0, 0, 0, 0);
    // R4 write beats update, sel 3 ignored
    step(1, 8'hE9, 0, 0, 0, 0, 1, 2, 12'h777);
    step(1, 0, 0, 0, 0, 0, 1, 3, 12'hABC);
    // R5 slots 5..7 are direct
    step(1, 8'hDD, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hEF, 0, 0, 0, 0, 0, 0, 0);
    // Banked alias reach through bank 15
    step(0, 0, 0, 0, 1, 15, 0, 0, 0);
    step(1, 8'hE1, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int f, b, pwd, sel;
      f = ($urandom % 2 == 0) ? (8'hD0 + $urandom % 32) : ($urandom % 256);
      b = ($urandom % 10 < 3) ? 1 : 0;
      case ($urandom % 5)
        0, 1: pwd = 4048 + $urandom % 32;
        2: pwd = (4094 + $urandom % 4) % 4096;
        default: pwd = $urandom % 4096;
      endcase
      sel = $urandom % 4;
      step(($urandom % 5 != 0) ? 1 : 0, f, b, $urandom % 256,
           ($urandom % 10 == 0) ? 1 : 0, $urandom % 16,
           ($urandom % 5 == 0) ? 1 : 0, sel, pwd);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule